// File: doc/BRIEF.md
# Chained-Descriptor Receive DMA

This engine takes frames from a byte-wide receive stream and places each one into memory. Frames are delimited by start and end markers and may carry an error marker. The engine walks a list of 64-byte descriptors that software links through a next pointer. Before it uses a descriptor, it reads the descriptor's first word. That word carries the ownership flag, and a descriptor is used only while the flag shows that software has handed it over. The frame's bytes are then written into the buffer that the descriptor names. When the frame ends, the engine writes back an error code and the stored length. It clears the ownership flag last, and then follows the link to the next descriptor.

Software drives the engine through a small register port with four word registers:

| Index | Register |
|---|---|
| 0 | control |
| 1 | status |
| 2 | list base |
| 3 | interrupt mask |

The status register keeps a count of completed frames that software has not yet acknowledged. The interrupt output is a level derived from that count and one mask bit. When the engine finds a descriptor it does not own, it discards incoming frames. It stays in that state until software writes the control register again, which usually happens after a refill.

Top module: `rxd_dma`

## Requirements
- R1: After reset the engine is off. In this state `rx_ready` is low, so the stream stalls, `mem_req` is low, `irq` is low and the status count reads 0. The engine leaves this state only on a write of 1 to bit 0 of register 0 (control), which loads the current descriptor address from register 2 (list base).
- R2: A descriptor is consumed only if bit 63 of its word 0, which is read first, is 1. Word 0 bits 31..0 give the buffer address, and word 1 (at +8) bits 31..0 give the next descriptor address. Byte i of the frame is written to buffer address + i, and nothing is written past the last byte of the frame.
- R3: On completion the engine first writes the top byte of word 2 (at +16): bits 63..62 carry the error code, bits 61..56 are zero and the rest of word 2 is untouched. It then writes word 0 as: bit 63 = 0, bits 62..44 = 0, bits 43..32 = stored length, bits 31..0 = buffer address.
- R4: For a frame longer than 1536 bytes, only the first 1536 bytes are written, the stored length is 1536 and bit 1 of the error code is set.
- R5: If the error marker is present on any byte of a frame, bit 0 of the error code is set. A frame with neither error nor truncation gets code 0.
- R6: Bits 23..16 of register 1 (status) count completed frames. Each completion adds 1, and each write of 1 to bit 0 of register 1 subtracts 1, never going below 0.
- R7: `irq` is high exactly while bit 4 of register 3 (mask) is 1 and the status count is nonzero.
- R8: If the fetched word 0 has bit 63 = 0, the engine keeps `rx_ready` high and writes nothing, so every frame is dropped. It re-reads that word 0 only after a control write, and that write may come at any time after the previous read was issued.
- R9: After a completion the engine moves to the linked descriptor, so a list whose last link points back to the first wraps around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index: 0 control, 1 status, 2 list base, 3 mask |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Received-frame interrupt level |
| rx_valid | input | 1 | Stream byte valid |
| rx_ready | output | 1 | Stream byte accepted |
| rx_data | input | 8 | Stream byte |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_err | input | 1 | Error marker on this byte |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address |
| mem_be | output | 8 | Byte enables of the 64-bit word |
| mem_wdata | output | 64 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid, one cycle after a granted read |
| mem_rdata | input | 64 | Read data |

## Verification
Each kind of wrong internal state shows up at the ports in its own way:

- **Length count off:** a buffer byte lands at the wrong address, or the written-back size field is wrong. Either is visible in memory as soon as the descriptor's ownership bit drops.
- **Wrong ownership state:** the engine writes into a descriptor that software still holds, or it stalls a frame it should have dropped. The bench sees this on `rx_ready` within the same frame.
- **Completion counter drift:** the `irq` level diverges from a model updated by observed word-0 writebacks and by the bench's own acknowledges. This is caught on the very next clock.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  typedef enum logic [3:0] {
    ST_OFF,
    ST_RD0,
    ST_RD0W,
    ST_RD1,
    ST_RD1W,
    ST_NOBUF,
    ST_READY,
    ST_STORE,
    ST_WB2,
    ST_WB0
  } rxd_state_e;

  localparam logic [1:0] REG_CTL  = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_BASE = 2'd2;
  localparam logic [1:0] REG_MASK = 2'd3;

  localparam int SIZE_W      = 12;
  localparam int OFS_WORD1   = 8;
  localparam int OFS_WORD2   = 16;
  localparam int STAT_CNT_LSB = 16;

endpackage

// File: rtl/rxd_regs.sv
module rxd_regs
  import rxd_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 8,
  parameter int MASK_W  = 8,
  parameter int IRQ_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              kick,
  output logic [ADDR_W-1:0] base,
  input  logic              pkt_done,
  input  logic              running,
  output logic              irq
);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [MASK_W-1:0] mask_q, mask_d;
  logic              ack, inc, dec, base_en, mask_en;

  assign kick    = reg_wr && (reg_addr == REG_CTL) && reg_wdata[0];
  assign ack     = reg_wr && (reg_addr == REG_STAT) && reg_wdata[0];
  assign base_en = reg_wr && (reg_addr == REG_BASE);
  assign mask_en = reg_wr && (reg_addr == REG_MASK);
  assign inc     = pkt_done && (cnt_q != {CNT_W{1'b1}});
  assign dec     = ack && (cnt_q != '0);

  always_comb begin
    cnt_d  = cnt_q;
    base_d = base_q;
    mask_d = mask_q;
    if (inc && !dec)      cnt_d = cnt_q + CNT_W'(1);
    else if (dec && !inc) cnt_d = cnt_q - CNT_W'(1);
    if (base_en) base_d = reg_wdata[ADDR_W-1:0];
    if (mask_en) mask_d = reg_wdata[MASK_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      base_q <= '0;
      mask_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (base_en) base_q <= base_d;
      if (mask_en) mask_q <= mask_d;
    end
  end

  always_comb begin
    case (reg_addr)
      REG_CTL:  reg_rdata = 32'(running);
      REG_STAT: reg_rdata = 32'(cnt_q) << STAT_CNT_LSB;
      REG_BASE: reg_rdata = 32'(base_q);
      default:  reg_rdata = 32'(mask_q);
    endcase
  end

  assign base = base_q;
  assign irq  = mask_q[IRQ_BIT] && (cnt_q != '0);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |->
      (($past(cnt_q) + CNT_W'(1) == cnt_q) || (cnt_q + CNT_W'(1) == $past(cnt_q)))); // R6

  AST_ACK_ONLY_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pkt_done) && !$past(ack)) |-> (cnt_q >= $past(cnt_q))); // R6

endmodule

// File: rtl/rxd_ctrl.sv
module rxd_ctrl
  import rxd_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BUF_BYTES = 1536
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kick,
  input  logic [ADDR_W-1:0] base,
  output logic              running,
  output logic              pkt_done,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic              rx_err,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_be,
  output logic [63:0]       mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [63:0]       mem_rdata
);

  localparam int LEN_W = $clog2(BUF_BYTES + 1);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(BUF_BYTES);

  rxd_state_e        state_q, state_d;
  logic [ADDR_W-1:0] cur_q, cur_d, next_q, next_d, buf_q, buf_d;
  logic [LEN_W-1:0]  len_q, len_d, len_base;
  logic              trunc_q, trunc_d, mark_q, mark_d;
  logic              own_q, own_d, mid_q, mid_d, kp_q, kp_d;
  logic              full, take, byte_wr, byte_fire;
  logic [ADDR_W-1:0] byte_addr;
  logic              unused_rdata;

  assign unused_rdata = ^mem_rdata[62:ADDR_W];

  assign len_base  = (state_q == ST_READY) ? '0 : len_q;
  assign full      = (len_base == LEN_MAX);
  assign take      = rx_valid && (((state_q == ST_READY) && rx_sof) || (state_q == ST_STORE));
  assign byte_wr   = take && !full;
  assign byte_fire = take && (full || mem_gnt);
  assign byte_addr = buf_q + ADDR_W'(len_base);
  assign running   = (state_q != ST_OFF);

  always_comb begin
    state_d   = state_q;
    cur_d     = cur_q;
    next_d    = next_q;
    buf_d     = buf_q;
    len_d     = len_q;
    trunc_d   = trunc_q;
    mark_d    = mark_q;
    own_d     = own_q;
    mid_d     = mid_q;
    kp_d      = kp_q || kick;
    pkt_done  = 1'b0;
    rx_ready  = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_q;
    mem_be    = '0;
    mem_wdata = '0;
    case (state_q)
      ST_OFF: begin
        if (kick) begin
          state_d = ST_RD0;
          cur_d   = base;
        end
      end
      ST_RD0: begin
        mem_req = 1'b1;
        if (mem_gnt) begin
          state_d = ST_RD0W;
          kp_d    = kick;
        end
      end
      ST_RD0W: begin
        if (mem_rvalid) begin
          if (mem_rdata[63]) begin
            own_d   = 1'b1;
            buf_d   = mem_rdata[ADDR_W-1:0];
            state_d = ST_RD1;
          end else begin
            state_d = ST_NOBUF;
          end
        end
      end
      ST_RD1: begin
        mem_req  = 1'b1;
        mem_addr = cur_q + ADDR_W'(OFS_WORD1);
        if (mem_gnt) state_d = ST_RD1W;
      end
      ST_RD1W: begin
        if (mem_rvalid) begin
          next_d  = mem_rdata[ADDR_W-1:0];
          state_d = ST_READY;
        end
      end
      ST_NOBUF: begin
        rx_ready = 1'b1;
        if (rx_valid) mid_d = !rx_eof && (rx_sof || mid_q);
        if (kp_q && !mid_q) begin
          state_d = ST_RD0;
          mid_d   = 1'b0;
        end
      end
      ST_READY, ST_STORE: begin
        if ((state_q == ST_READY) && !rx_sof) rx_ready = 1'b1;
        else                                  rx_ready = full || mem_gnt;
        mem_req   = byte_wr;
        mem_we    = 1'b1;
        mem_addr  = byte_addr;
        mem_be    = 8'b1 << byte_addr[2:0];
        mem_wdata = {8{rx_data}};
        if (byte_fire) begin
          len_d   = full ? len_base : len_base + LEN_W'(1);
          trunc_d = ((state_q == ST_STORE) && trunc_q) || full;
          mark_d  = ((state_q == ST_STORE) && mark_q) || rx_err;
          state_d = rx_eof ? ST_WB2 : ST_STORE;
        end
      end
      ST_WB2: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur_q + ADDR_W'(OFS_WORD2);
        mem_be    = 8'h80;
        mem_wdata = {trunc_q, mark_q, 62'd0};
        if (mem_gnt) state_d = ST_WB0;
      end
      ST_WB0: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_be    = 8'hFF;
        mem_wdata = {1'b0, 19'd0, SIZE_W'(len_q), 32'(buf_q)};
        if (mem_gnt) begin
          pkt_done = 1'b1;
          own_d    = 1'b0;
          cur_d    = next_q;
          state_d  = ST_RD0;
        end
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      cur_q   <= '0;
      next_q  <= '0;
      buf_q   <= '0;
      len_q   <= '0;
      trunc_q <= 1'b0;
      mark_q  <= 1'b0;
      own_q   <= 1'b0;
      mid_q   <= 1'b0;
      kp_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      next_q  <= next_d;
      buf_q   <= buf_d;
      len_q   <= len_d;
      trunc_q <= trunc_d;
      mark_q  <= mark_d;
      own_q   <= own_d;
      mid_q   <= mid_d;
      kp_q    <= kp_d;
    end
  end

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OFF) |-> (!mem_req && !rx_ready)); // R1

  AST_OWN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_STORE) || (state_q == ST_WB2) || (state_q == ST_WB0)) |-> own_q); // R2

  AST_WB_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WB0) |-> (($past(state_q) == ST_WB2) || ($past(state_q) == ST_WB0))); // R3

  AST_BUF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && ((state_q == ST_READY) || (state_q == ST_STORE)))
      |-> ((mem_addr - buf_q) < ADDR_W'(BUF_BYTES))); // R4

  AST_SIZE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && (mem_be == 8'hFF)) |-> (mem_wdata[43:32] <= SIZE_W'(BUF_BYTES))); // R4

  AST_NOBUF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_NOBUF) |-> (!mem_req && rx_ready)); // R8

endmodule

// File: rtl/rxd_dma.sv
module rxd_dma
  import rxd_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BUF_BYTES = 1536,
  parameter int CNT_W     = 8,
  parameter int MASK_W    = 8,
  parameter int IRQ_BIT   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic              rx_err,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_be,
  output logic [63:0]       mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [63:0]       mem_rdata
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              kick, pkt_done, running;
  logic [ADDR_W-1:0] base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rxd_regs #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .MASK_W (MASK_W),
    .IRQ_BIT(IRQ_BIT)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .kick     (kick),
    .base     (base),
    .pkt_done (pkt_done),
    .running  (running),
    .irq      (irq)
  );

  rxd_ctrl #(
    .ADDR_W   (ADDR_W),
    .BUF_BYTES(BUF_BYTES)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .kick      (kick),
    .base      (base),
    .running   (running),
    .pkt_done  (pkt_done),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .rx_data   (rx_data),
    .rx_sof    (rx_sof),
    .rx_eof    (rx_eof),
    .rx_err    (rx_err),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .mem_gnt   (mem_gnt),
    .mem_rvalid(mem_rvalid),
    .mem_rdata (mem_rdata)
  );

endmodule

// File: tb/sim_rxd_dma.sv
`timescale 1ns/1ps
module sim_rxd_dma;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  rx_data = 8'd0;
  logic        rx_sof = 1'b0, rx_eof = 1'b0, rx_err = 1'b0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [7:0]  mem_be;
  logic [63:0] mem_wdata;
  logic        mem_gnt = 1'b0;
  logic        mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = 64'd0;

  always #2.5 clk = ~clk;

  rxd_dma u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata)
  );

  int nvec = 0;
  int nerr = 0;
  bit fin = 1'b0;
  bit cmp_on = 1'b0;

  // behavioural memory with a software-side write port
  logic [63:0] mem [0:1023];
  logic        sw_we = 1'b0;
  int          sw_idx = 0;
  logic [63:0] sw_data = 64'd0;
  logic        fill = 1'b0;
  int          gcnt = 0;

  // reference model state
  int mcnt = 0;
  bit mmask = 1'b0;

  always @(negedge clk) begin
    gcnt++;
    mem_gnt <= (gcnt % 4) != 3;
  end

  always @(posedge clk) begin
    if (fill) begin
      for (int i = 0; i < 1024; i++) mem[i] <= {8{8'hEE}};
    end else if (sw_we) begin
      mem[sw_idx] <= sw_data;
    end else if (mem_req && mem_gnt && mem_we) begin
      for (int b = 0; b < 8; b++)
        if (mem_be[b]) mem[mem_addr[12:3]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
    end
    mem_rvalid <= mem_req && mem_gnt && !mem_we;
    mem_rdata  <= mem[mem_addr[12:3]];
  end

  always @(posedge clk) begin
    automatic int inc = 0;
    automatic int dec = 0;
    if (mem_req && mem_gnt && mem_we && mem_be == 8'hFF && mem_addr[5:0] == 6'd0 &&
        mem_addr < 32'h400 && !mem_wdata[63] && mcnt < 255) inc = 1;
    if (reg_wr && reg_addr == 2'd1 && reg_wdata[0] && mcnt > 0) dec = 1;
    mcnt <= mcnt + inc - dec;
    if (reg_wr && reg_addr == 2'd3) mmask <= reg_wdata[4];
  end

  // cycle-by-cycle comparison of the interrupt level against the model
  always @(negedge clk) begin
    if (cmp_on && !fin) begin
      nvec++;
      if (irq !== (mmask && mcnt != 0)) begin
        nerr++;
        $display("FAIL R7 cycle compare: actual irq=%0b expected=%0b", irq, (mmask && mcnt != 0));
      end
    end
  end

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic sw_write(input int idx, input logic [63:0] d);
    @(negedge clk);
    sw_we = 1'b1; sw_idx = idx; sw_data = d;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [7:0] mbyte(input int a);
    return mem[a >> 3][(a % 8) * 8 +: 8];
  endfunction

  task automatic send_frame(input int n, input logic [7:0] seed, input int err_at,
                            output int stalls);
    stalls = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = seed + 8'(i);
      rx_sof = (i == 0); rx_eof = (i == n - 1); rx_err = (i == err_at);
      forever begin
        #2;
        if (rx_ready) break;
        stalls++;
        @(negedge clk);
      end
      @(posedge clk);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0;
  endtask

  task automatic wait_owner_clear(input int idx, input string rq);
    int t;
    for (t = 0; t < 8000; t++) begin
      @(negedge clk);
      if (mem[idx][63] == 1'b0) break;
    end
    chk({rq, " completion seen"}, 64'(t < 8000), 64'd1);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!fin) begin
      nerr++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int st, bad;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_on = 1'b1;

    // R1: reset state and stall while off
    chk("R1 rx_ready off", 64'(rx_ready), 64'd0);
    chk("R1 mem_req off", 64'(mem_req), 64'd0);
    chk("R1 irq off", 64'(irq), 64'd0);
    reg_read(2'd1, rd);
    chk("R1 status count", 64'(rd[23:16]), 64'd0);
    rx_valid = 1'b1; rx_sof = 1'b1;
    repeat (3) @(negedge clk);
    #2 chk("R1 stream stalled while off", 64'(rx_ready), 64'd0);
    @(negedge clk); rx_valid = 1'b0; rx_sof = 1'b0;

    // memory and descriptor ring: D0@0x000 -> D1@0x040 -> D2@0x080 -> D0
    @(negedge clk); fill = 1'b1; @(negedge clk); fill = 1'b0;
    sw_write(1,  64'h0000_0000_0000_0040);
    sw_write(2,  64'h0000_0000_0000_1234);
    sw_write(0,  {1'b1, 31'd0, 32'h0000_0400});
    sw_write(9,  64'h0000_0000_0000_0080);
    sw_write(10, 64'h0000_0000_0000_0000);
    sw_write(8,  {1'b1, 31'd0, 32'h0000_0A00});
    sw_write(17, 64'h0000_0000_0000_0000);
    sw_write(18, 64'h3FFF_FFFF_FFFF_FFFF);
    sw_write(16, {1'b0, 31'd0, 32'h0000_1000});

    reg_write(2'd2, 32'h0);
    reg_write(2'd3, 32'h10);
    reg_read(2'd2, rd);
    chk("R1 base readback", 64'(rd), 64'd0);
    reg_write(2'd0, 32'h1);

    // frame A: 10 bytes, clean
    send_frame(10, 8'h10, -1, st);
    wait_owner_clear(0, "R3 frame A");
    chk("R3 word0 A", mem[0], 64'h0000_000A_0000_0400);
    chk("R3 word2 A untouched low part", mem[2], 64'h0000_0000_0000_1234);
    bad = 0;
    for (int i = 0; i < 10; i++) if (mbyte(32'h400 + i) !== 8'(8'h10 + i)) bad++;
    chk("R2 frame A bytes", 64'(bad), 64'd0);
    chk("R2 no write past frame A", 64'(mbyte(32'h40A)), 64'hEE);
    reg_read(2'd1, rd);
    chk("R6 count after A", 64'(rd[23:16]), 64'd1);
    chk("R7 irq after A", 64'(irq), 64'd1);

    // frame B: 1540 bytes, truncated
    send_frame(1540, 8'h80, -1, st);
    wait_owner_clear(8, "R4 frame B");
    chk("R4 word0 B size capped", mem[8], 64'h0000_0600_0000_0A00);
    chk("R4 word2 B code", mem[10], 64'h8000_0000_0000_0000);
    bad = 0;
    for (int i = 0; i < 1536; i++) if (mbyte(32'hA00 + i) !== 8'(8'h80 + i)) bad++;
    chk("R4 first 1536 bytes of B", 64'(bad), 64'd0);
    chk("R4 nothing past buffer", 64'(mbyte(32'h1000)), 64'hEE);
    reg_read(2'd1, rd);
    chk("R6 count after B", 64'(rd[23:16]), 64'd2);

    // frame C: D2 not owned, frame dropped
    repeat (10) @(negedge clk);
    send_frame(5, 8'h44, -1, st);
    repeat (10) @(negedge clk);
    chk("R8 no stall while dropping", 64'(st), 64'd0);
    chk("R8 D2 word0 unchanged", mem[16], {1'b0, 31'd0, 32'h0000_1000});
    chk("R8 D2 buffer untouched", mem[512], {8{8'hEE}});
    reg_read(2'd1, rd);
    chk("R8 count unchanged by drop", 64'(rd[23:16]), 64'd2);

    // acknowledges
    reg_write(2'd1, 32'h1);
    reg_write(2'd1, 32'h1);
    reg_read(2'd1, rd);
    chk("R6 count after acks", 64'(rd[23:16]), 64'd0);
    chk("R7 irq cleared", 64'(irq), 64'd0);
    reg_write(2'd1, 32'h1);
    reg_read(2'd1, rd);
    chk("R6 no underflow", 64'(rd[23:16]), 64'd0);

    // refill D2, kick, frame D: single byte with error marker
    sw_write(16, {1'b1, 31'd0, 32'h0000_1000});
    reg_write(2'd0, 32'h1);
    send_frame(1, 8'h5A, 0, st);
    wait_owner_clear(16, "R5 frame D");
    chk("R8 reread after kick, word0 D", mem[16], 64'h0000_0001_0000_1000);
    chk("R5 word2 D error code", mem[18], 64'h40FF_FFFF_FFFF_FFFF);
    chk("R2 single byte stored", 64'(mbyte(32'h1000)), 64'h5A);
    chk("R2 no write after single byte", 64'(mbyte(32'h1001)), 64'hEE);

    // ring wraps to D0 (not owned); mask off, refill, frame E
    reg_write(2'd3, 32'h0);
    chk("R7 irq masked with count 1", 64'(irq), 64'd0);
    sw_write(2, 64'd0);
    sw_write(0, {1'b1, 31'd0, 32'h0000_0400});
    reg_write(2'd0, 32'h1);
    send_frame(64, 8'h33, 20, st);
    wait_owner_clear(0, "R9 frame E");
    chk("R9 wrap to D0 word0", mem[0], 64'h0000_0040_0000_0400);
    chk("R5 mid-frame error code", mem[2], 64'h4000_0000_0000_0000);
    bad = 0;
    for (int i = 0; i < 64; i++) if (mbyte(32'h400 + i) !== 8'(8'h33 + i)) bad++;
    chk("R9 frame E bytes", 64'(bad), 64'd0);
    reg_read(2'd1, rd);
    chk("R6 count after E", 64'(rd[23:16]), 64'd2);
    chk("R7 irq stays masked", 64'(irq), 64'd0);

    repeat (4) @(negedge clk);
    fin = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule